// File: doc/BRIEF.md
# Single-Byte Serial Peripheral Master

This block is a serial peripheral (SPI) master that sends and receives one 8-bit frame for each start command from software. Software reaches it through a small byte-wide register bank. The bank holds:

- the transfer mode,
- the byte to transmit,
- the byte last received,
- a control register that launches a frame,
- a status register,
- a clock divisor.

The serial clock comes from the bus clock divided by four times (divisor + 1). The frame shifts in full duplex. Both clock polarities are supported. An edge-select bit picks which clock edge latches data; this bit is the inverse of the usual clock-phase setting. Bits go out MSB-first or LSB-first. A loopback bit feeds the transmit shifter straight back into the receive shifter.

There is no buffering, so each finished frame raises the receive-ready flag and the interrupt once. Software reads the received byte, which clears both, and then writes the next byte. Chip selects and pin sharing with other buses are handled outside the block.

The sequencer has three states:

- `ST_IDLE`: the clock rests at its idle level. An accepted start moves to `ST_SHIFT`.
- `ST_SHIFT`: sixteen half-period ticks toggle the serial clock. The sixteenth tick moves to `ST_DONE`, and at that same edge the received byte is captured and receive-ready is set.
- `ST_DONE`: lasts exactly one cycle with busy still high, then returns to `ST_IDLE`.

Top module: `spi_byte_master`

## Requirements
- R1: Register offsets are 0 mode, 1 receive data, 2 transmit data, 3 control, 4 status and 6 divisor. Mode, transmit data and divisor read back what was written. Offsets 5 and 7 and the control register always read 0, so the start bit clears itself.
- R2: The mode register bits are 0x10 edge-select, 0x08 port-enable, 0x04 bit-reverse, 0x02 clock-idle and 0x01 loopback. Bits 7:5 read 0.
- R3: During a frame each serial clock half period lasts 2*(divisor+1) bus cycles, which gives a serial clock of bus/(4*(divisor+1)). Receive-ready becomes visible 32*(divisor+1)+1 bus cycles after the cycle in which start was written.
- R4: While no frame is in progress, the serial clock sits at the clock-idle level: low for 0, high for 1.
- R5: A frame is exactly 8 bits in full duplex. With edge-select 1, bits are latched on the leading clock edge and the output changes on trailing edges. With edge-select 0, the output changes on leading edges (from the second one on) and bits are latched on trailing edges.
- R6: With bit-reverse 0, bit 7 goes out and comes in first. With bit-reverse 1, bit 0 is first.
- R7: With loopback 1, the received byte equals the transmitted byte, whatever the input data line carries.
- R8: At the end of a frame, status bit 0x01 (receive-ready) and the interrupt rise together. Status bit 0x02 (busy) is still 1 in that cycle and is 0 in the next one.
- R9: Reading offset 1 clears receive-ready and drops the interrupt.
- R10: A start written while busy is ignored: no second frame follows.
- R11: With port-enable 0, the serial clock holds its idle level, the output data line is low and a start is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rd | input | 1 | Register read strobe (has side effects on offset 1) |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| irq | output | 1 | Frame-complete interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The assertions check the following on every cycle:

- the serial clock sits at its idle level whenever the sequencer is idle;
- the clock toggles on every half-period tick inside a frame;
- busy is high when the interrupt rises and low one cycle later;
- a disabled port stays quiet;
- a read of the receive register clears the ready flag.

Some behaviours only the directed scenarios can show, because they need a model of the far end. These are the exact frame length for a given divisor, the bit order and the latching edge in all four clock modes, loopback, and the rejection of a start while a frame is running.

// File: rtl/spi_byte_pkg.sv
`timescale 1ns/1ps
package spi_byte_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } xfer_state_t;

    // Packed order gives mode-register bit positions 4..0.
    typedef struct packed {
        logic esel;    // 1: latch on leading edge
        logic enable;  // port enable
        logic rev;     // 1: LSB first
        logic cpol;    // clock idle level
        logic loopb;   // internal loopback
    } mode_t;

    localparam int MODE_BITS = 5;

    localparam logic [2:0] OFF_MODE = 3'd0;
    localparam logic [2:0] OFF_RXD  = 3'd1;
    localparam logic [2:0] OFF_TXD  = 3'd2;
    localparam logic [2:0] OFF_CTRL = 3'd3;
    localparam logic [2:0] OFF_STAT = 3'd4;
    localparam logic [2:0] OFF_DIV  = 3'd6;
endpackage

// File: rtl/spi_byte_regs.sv
`timescale 1ns/1ps
module spi_byte_regs
    import spi_byte_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       addr,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    input  logic             rd_en,
    output logic [DW-1:0]    rd_data,
    input  logic             busy,
    input  logic             done,
    input  logic [DW-1:0]    rx_byte,
    output mode_t            mode,
    output logic [DW-1:0]    tx_byte,
    output logic [DIV_W-1:0] div,
    output logic             go,
    output logic             irq
);
    mode_t            mode_q;
    logic [DW-1:0]    tx_q;
    logic [DW-1:0]    rx_q;
    logic [DIV_W-1:0] div_q;
    logic             ready_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            tx_q    <= '0;
            div_q   <= '0;
            rx_q    <= '0;
            ready_q <= 1'b0;
        end else begin
            if (wr_en) begin
                unique case (addr)
                    OFF_MODE: mode_q <= mode_t'(wr_data[MODE_BITS-1:0]);
                    OFF_TXD:  tx_q   <= wr_data;
                    OFF_DIV:  div_q  <= wr_data[DIV_W-1:0];
                    default:  ;
                endcase
            end
            if (done) begin
                rx_q    <= rx_byte;
                ready_q <= 1'b1;
            end else if (rd_en && addr == OFF_RXD) begin
                ready_q <= 1'b0;
            end
        end
    end

    always_comb begin
        go = wr_en && (addr == OFF_CTRL) && wr_data[0] && mode_q.enable && !busy;
        unique case (addr)
            OFF_MODE: rd_data = {{(DW-MODE_BITS){1'b0}}, mode_q};
            OFF_RXD:  rd_data = rx_q;
            OFF_TXD:  rd_data = tx_q;
            OFF_STAT: rd_data = {{(DW-2){1'b0}}, busy, ready_q};
            OFF_DIV:  rd_data = {{(DW-DIV_W){1'b0}}, div_q};
            default:  rd_data = '0;
        endcase
    end

    assign mode    = mode_q;
    assign tx_byte = tx_q;
    assign div     = div_q;
    assign irq     = ready_q;

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == OFF_RXD && !done) |=> !irq); // R9
endmodule

// File: rtl/spi_byte_clkgen.sv
`timescale 1ns/1ps
module spi_byte_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    // half period = 2*(div+1) cycles
    assign limit = {div, 1'b1};
    assign tick  = run && (cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (!run)   cnt <= '0;
        else if (tick)   cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spi_byte_shifter.sv
`timescale 1ns/1ps
module spi_byte_shifter
    import spi_byte_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [DW-1:0] tx_byte,
    input  mode_t         mode,
    input  logic          tick,
    input  logic          miso,
    output logic          run,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rx_byte,
    output logic          sclk,
    output logic          mosi
);
    localparam int EDGES  = 2 * DW;
    localparam int EDGE_W = $clog2(EDGES);
    localparam logic [EDGE_W-1:0] LAST = EDGE_W'(EDGES - 1);

    xfer_state_t      state, state_nx;
    logic [EDGE_W-1:0] edge_cnt;
    logic [DW-1:0]    tsr, rsr, rsr_nx;
    logic             sclk_q;
    logic             leading, sample_edge, out_bit, in_bit, last_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        last_tick = (state == ST_SHIFT) && tick && (edge_cnt == LAST);
        state_nx  = state;
        unique case (state)
            ST_IDLE:  if (go) state_nx = ST_SHIFT;
            ST_SHIFT: if (last_tick) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        leading     = (sclk_q == mode.cpol);
        sample_edge = (leading == mode.esel);
        out_bit     = mode.rev ? tsr[0] : tsr[DW-1];
        in_bit      = mode.loopb ? out_bit : miso;
        rsr_nx      = rsr;
        if (state == ST_SHIFT && tick && sample_edge)
            rsr_nx = mode.rev ? {in_bit, rsr[DW-1:1]} : {rsr[DW-2:0], in_bit};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tsr      <= '0;
            rsr      <= '0;
            edge_cnt <= '0;
            sclk_q   <= 1'b0;
        end else if (state == ST_IDLE) begin
            sclk_q <= mode.cpol;
            if (go) begin
                tsr      <= tx_byte;
                rsr      <= '0;
                edge_cnt <= '0;
            end
        end else if (state == ST_SHIFT && tick) begin
            sclk_q   <= ~sclk_q;
            edge_cnt <= edge_cnt + 1'b1;
            rsr      <= rsr_nx;
            if (!sample_edge && edge_cnt != '0)
                tsr <= mode.rev ? {1'b0, tsr[DW-1:1]} : {tsr[DW-2:0], 1'b0};
        end
    end

    always_comb begin
        run     = (state == ST_SHIFT);
        busy    = (state != ST_IDLE);
        done    = last_tick;
        rx_byte = rsr_nx;
        sclk    = (state == ST_SHIFT && mode.enable) ? sclk_q : mode.cpol;
        mosi    = (busy && mode.enable) ? out_bit : 1'b0;
    end

    AST_SCLK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (sclk == mode.cpol)); // R4
    AST_SCLK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && tick && edge_cnt != LAST && mode.enable && $stable(mode))
        |=> (sclk != $past(sclk))); // R3
endmodule

// File: rtl/spi_byte_master.sv
`timescale 1ns/1ps
module spi_byte_master
    import spi_byte_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DIV_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    reg_addr,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    input  logic          reg_rd,
    output logic [DW-1:0] reg_rdata,
    output logic          irq,
    output logic          sclk,
    output logic          mosi,
    input  logic          miso
);
    mode_t            mode;
    logic [DW-1:0]    tx_byte, rx_byte;
    logic [DIV_W-1:0] div;
    logic             go, busy, done, run, tick;

    spi_byte_regs #(.DW(DW), .DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr_en(reg_wr),
        .wr_data(reg_wdata), .rd_en(reg_rd), .rd_data(reg_rdata),
        .busy(busy), .done(done), .rx_byte(rx_byte), .mode(mode),
        .tx_byte(tx_byte), .div(div), .go(go), .irq(irq)
    );

    spi_byte_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .run(run), .div(div), .tick(tick)
    );

    spi_byte_shifter #(.DW(DW)) u_shift (
        .clk(clk), .rst_n(rst_n), .go(go), .tx_byte(tx_byte), .mode(mode),
        .tick(tick), .miso(miso), .run(run), .busy(busy), .done(done),
        .rx_byte(rx_byte), .sclk(sclk), .mosi(mosi)
    );

    AST_BUSY_AT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> busy); // R8
    AST_BUSY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |=> !busy); // R8
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !mode.enable |-> (!mosi && sclk == mode.cpol)); // R11
    AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode.enable && !busy) |=> !busy); // R11
endmodule

// File: tb/spi_byte_master_test.sv
`timescale 1ns/1ps
module spi_byte_master_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_rdata;
    logic       irq, sclk, mosi, miso;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // far-end model
    logic       slv_on = 1'b0;
    logic       slv_esel = 1'b0, slv_cpol = 1'b0, slv_rev = 1'b0;
    logic [7:0] slv_byte = 8'd0;
    logic [7:0] slv_got = 8'd0;
    int         slv_idx = 0;
    int         slv_smp = 0;
    int         slv_drv = 0;

    always #2.5 clk = ~clk;

    spi_byte_master uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    assign miso = slv_rev ? slv_byte[slv_idx[2:0]] : slv_byte[3'd7 - slv_idx[2:0]];

    always @(sclk) begin
        if (slv_on) begin
            if (((sclk != slv_cpol) ? 1'b1 : 1'b0) == slv_esel) begin
                if (slv_smp < 8) begin
                    if (slv_rev) slv_got[slv_smp] = mosi;
                    else         slv_got[7 - slv_smp] = mosi;
                end
                slv_smp = slv_smp + 1;
            end else begin
                if (slv_drv > 0 || slv_esel) begin
                    if (slv_idx < 7) slv_idx = slv_idx + 1;
                end
                slv_drv = slv_drv + 1;
            end
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: run did not end (actual %0d cycles, expected < 150000)", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd_pop(output logic [7:0] d);
        @(negedge clk);
        reg_addr = 3'd1; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(posedge clk);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] s;
        check(irq == 1'b0, "R8 reset irq", irq, 0);
        check(sclk == 1'b0, "R4 reset sclk", sclk, 0);
        check(mosi == 1'b0, "R11 reset mosi", mosi, 0);
        peek(3'd4, s);
        check(s == 8'h00, "R8 reset status", s, 0);
    endtask

    task automatic t_regs;
        logic [7:0] v;
        wr(3'd0, 8'hFF);
        peek(3'd0, v); check(v == 8'h1F, "R2 mode readback masks 7:5", v, 8'h1F);
        wr(3'd0, 8'h00);
        wr(3'd2, 8'hA7); peek(3'd2, v); check(v == 8'hA7, "R1 txd readback", v, 8'hA7);
        wr(3'd6, 8'h5C); peek(3'd6, v); check(v == 8'h5C, "R1 divisor readback", v, 8'h5C);
        wr(3'd3, 8'h01); peek(3'd3, v); check(v == 8'h00, "R1 control reads 0", v, 0);
        wr(3'd5, 8'hFF); peek(3'd5, v); check(v == 8'h00, "R1 offset 5 reads 0", v, 0);
        peek(3'd7, v); check(v == 8'h00, "R1 offset 7 reads 0", v, 0);
        wr(3'd0, 8'h02);
        #1 check(sclk == 1'b1, "R4 idle high after clock-idle=1", sclk, 1);
        wr(3'd0, 8'h00);
        #1 check(sclk == 1'b0, "R4 idle low after clock-idle=0", sclk, 0);
    endtask

    // mode byte: 0x10 edge-select, 0x08 enable, 0x04 reverse, 0x02 idle, 0x01 loop
    task automatic run_frame(input logic [7:0] mode_v, input logic [7:0] div_v,
                             input logic [7:0] tx_v, input logic [7:0] far_v,
                             input logic [7:0] exp_rx, input string tag);
        int n;
        logic [7:0] s, r;
        wr(3'd0, mode_v);
        wr(3'd6, div_v);
        wr(3'd2, tx_v);
        slv_esel = mode_v[4]; slv_cpol = mode_v[1]; slv_rev = mode_v[2];
        slv_byte = far_v; slv_got = 8'd0; slv_idx = 0; slv_smp = 0; slv_drv = 0;
        slv_on = 1'b1;
        wr(3'd3, 8'h01);
        reg_addr = 3'd4;
        n = 1;
        #1 s = reg_rdata;
        while (!s[0] && n < 20000) begin
            @(negedge clk); n++;
            #1 s = reg_rdata;
        end
        check(n == 32 * (int'(div_v) + 1) + 1, {"R3 frame length ", tag}, n, 32 * (int'(div_v) + 1) + 1);
        check(s[1] == 1'b1, {"R8 busy high with ready ", tag}, s, 8'h03);
        check(irq == 1'b1, {"R8 irq with ready ", tag}, irq, 1);
        @(negedge clk); #1 s = reg_rdata;
        check(s == 8'h01, {"R8 busy cleared next cycle ", tag}, s, 8'h01);
        slv_on = 1'b0;
        check(sclk == mode_v[1], {"R4 idle level after frame ", tag}, sclk, mode_v[1]);
        check(slv_smp == 8, {"R5 eight latching edges ", tag}, slv_smp, 8);
        check(slv_got == tx_v, {"R5 R6 far end got tx ", tag}, slv_got, tx_v);
        rd_pop(r);
        check(r == exp_rx, {"R5 R6 R7 received byte ", tag}, r, exp_rx);
    endtask

    task automatic t_modes;
        run_frame(8'h18, 8'd0, 8'hA5, 8'h3C, 8'h3C, "mode0 msb");
        run_frame(8'h08, 8'd1, 8'h81, 8'hC6, 8'hC6, "mode1 msb");
        run_frame(8'h1E, 8'd3, 8'h4B, 8'h92, 8'h92, "mode2 lsb");
        run_frame(8'h0E, 8'd0, 8'h17, 8'hE8, 8'hE8, "mode3 lsb");
        run_frame(8'h19, 8'd0, 8'h6D, 8'h00, 8'h6D, "R7 loopback mode0");
        run_frame(8'h0D, 8'd2, 8'hC3, 8'hFF, 8'hC3, "R7 loopback lsb mode1");
    endtask

    task automatic t_read_clear;
        logic [7:0] s;
        wr(3'd0, 8'h19); wr(3'd6, 8'd0); wr(3'd2, 8'h55);
        wr(3'd3, 8'h01);
        repeat (60) @(negedge clk);
        check(irq == 1'b1, "R8 irq set after frame", irq, 1);
        rd_pop(s);
        check(s == 8'h55, "R7 loopback data", s, 8'h55);
        check(irq == 1'b0, "R9 irq cleared by read", irq, 0);
        peek(3'd4, s);
        check(s == 8'h00, "R9 ready cleared by read", s, 0);
    endtask

    task automatic t_busy_start;
        logic [7:0] s;
        int seen = 0;
        wr(3'd0, 8'h19); wr(3'd6, 8'd1); wr(3'd2, 8'h9A);
        wr(3'd3, 8'h01);
        repeat (10) @(negedge clk);
        wr(3'd2, 8'h11);
        wr(3'd3, 8'h01);
        repeat (80) @(negedge clk);
        reg_addr = 3'd4;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk); #1;
            if (reg_rdata[1]) seen++;
        end
        check(seen == 0, "R10 no second frame after busy start", seen, 0);
        rd_pop(s);
        check(s == 8'h9A, "R10 first byte kept", s, 8'h9A);
    endtask

    task automatic t_disable;
        logic [7:0] s;
        int errs = 0;
        wr(3'd0, 8'h02); wr(3'd2, 8'hFF); wr(3'd6, 8'd0);
        wr(3'd3, 8'h01);
        reg_addr = 3'd4;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk); #1;
            if (reg_rdata[1] || sclk != 1'b1 || mosi != 1'b0) errs++;
        end
        check(errs == 0, "R11 disabled port quiet, start ignored", errs, 0);
        peek(3'd4, s);
        check(s == 8'h00, "R11 no ready when disabled", s, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_regs;
        t_modes;
        t_read_clear;
        t_busy_start;
        t_disable;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule